// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block receives asynchronous serial frames on a single line. Each frame carries nine payload bits, and the block is meant for shared multidrop buses. A ninth bit of 1 tags the frame as an address and a ninth bit of 0 tags it as data.

The line is oversampled from a tick input. The block confirms the start bit at mid-bit and takes each payload bit by a three-sample majority vote. The assembled word is handed to a one-entry holding buffer that presents it on a valid/ready output stream.

A filter-enable input, owned entirely by software, decides which frames may reach the buffer:
- **Enable set:** only address frames are kept and data frames vanish silently.
- **Enable clear:** every frame is kept.

Software typically leaves the filter on, inspects each address that arrives, and clears the filter once the address is its own so that the following data comes through. The block also reports two conditions:
- a per-word framing error;
- an overrun when an accepted word finds the buffer still occupied.

Top module: `uart9_addr_rx`

## Requirements
- R1: The line idles high. A frame is one low start bit, nine payload bits with bit0 first and bit8 last, and one high stop bit. Each bit lasts OVS ticks of `samp_tick_i`. An accepted word appears with bit0 on `out_data_o[0]` and bit8 on `out_data_o[8]`.
- R2: While `addr_filter_en_i` is 1, a completed frame whose bit8 is 0 leaves `out_valid_o`, `out_data_o`, `frame_err_o` and `overrun_o` untouched.
- R3: While `addr_filter_en_i` is 1, a completed frame whose bit8 is 1 is loaded into the buffer and raises `out_valid_o`.
- R4: While `addr_filter_en_i` is 0, every completed frame is loaded into the buffer whatever its bit8.
- R5: The filter decision uses the value of `addr_filter_en_i` at the end of the frame, so a change made while a frame is arriving applies to that frame.
- R6: `out_valid_o` rises only at the end of the stop bit of an accepted frame. It falls in the cycle after a read, a read being `out_valid_o && out_ready_i`.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` holds its value.
- R8: `frame_err_o` accompanies the buffered word: it is 1 when that frame's stop bit sampled low and 0 otherwise. A frame that was filtered out sets no error.
- R9: An accepted frame that completes while the buffer holds an unread word is discarded and sets `overrun_o`. `overrun_o` clears on the next read.
- R10: A low pulse on the line shorter than half a bit does not start a frame and produces no word.
- R11: After reset `out_valid_o`, `overrun_o` and `frame_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| samp_tick_i | input | 1 | One-cycle pulse at OVS times the bit rate |
| addr_filter_en_i | input | 1 | 1: keep only frames with bit8 = 1 |
| out_valid_o | output | 1 | Buffer holds an unread word |
| out_ready_i | input | 1 | Consumer takes the word when valid is high |
| out_data_o | output | DW | Buffered word, bit8 in the top position |
| frame_err_o | output | 1 | Stop bit of the buffered word sampled low |
| overrun_o | output | 1 | An accepted word was lost to a full buffer |

## Verification
The assertions assume the following about the inputs:
- `samp_tick_i` pulses no more often than every clock.
- The line changes only at bit boundaries of a rate matching OVS ticks per bit.
- The framer therefore produces at most one end-of-frame pulse per frame, never on consecutive cycles.

The bench honours this by spacing ticks every second clock and holding each line level for exactly one bit time of 32 clocks. It changes the filter enable and the ready strobe only on falling clock edges. The only deliberate break in line timing is the short glitch used for R10, which the start check must absorb.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart9_rx_sampler.sv
module uart9_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic tick_i,
  output logic rx_s_o,
  output logic vote_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;

  // line synchroniser, resets to the idle level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign rx_s_o = sync_q[SYNC_STAGES-1];

  // two previous tick samples; the current one completes the vote
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hist_q <= 2'b11;
    else if (tick_i) hist_q <= {hist_q[0], rx_s_o};
  end

  assign vote_o = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_s_o) | (hist_q[0] & rx_s_o);
endmodule

// File: rtl/uart9_rx_framer.sv
module uart9_rx_framer
  import uart9_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_s_i,
  input  logic          vote_i,
  output logic          done_o,
  output logic [DW-1:0] word_o,
  output logic          ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] shreg_q;
  logic          stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      stop_q  <= 1'b1;
      done_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rx_s_i) begin
              state_q <= RX_START;
              cnt_q   <= CW'(1);
            end
          end
          RX_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID_CNT && vote_i) begin
              state_q <= RX_IDLE;
            end else if (cnt_q == LAST_CNT) begin
              state_q <= RX_DATA;
              cnt_q   <= '0;
              bit_q   <= '0;
            end
          end
          RX_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID_CNT) shreg_q <= {vote_i, shreg_q[DW-1:1]};
            if (cnt_q == LAST_CNT) begin
              cnt_q <= '0;
              if (bit_q == LAST_BIT) state_q <= RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end
          end
          RX_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID_CNT) stop_q <= vote_i;
            if (cnt_q == LAST_CNT) begin
              state_q <= RX_IDLE;
              cnt_q   <= '0;
              done_o  <= 1'b1;
              ferr_o  <= ~stop_q;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign word_o = shreg_q;
endmodule

// File: rtl/uart9_rx_buffer.sv
module uart9_rx_buffer #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] word_i,
  input  logic          ferr_i,
  input  logic          filter_en_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output logic          overrun_o
);
  logic accept, pop;

  assign accept = done_i & (~filter_en_i | word_i[DW-1]);
  assign pop    = valid_o & ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      ferr_o    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (pop) begin
        valid_o   <= 1'b0;
        overrun_o <= 1'b0;
      end
      if (accept) begin
        if (valid_o && !pop) begin
          overrun_o <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= word_i;
          ferr_o  <= ferr_i;
        end
      end
    end
  end
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          samp_tick_i,
  input  logic          addr_filter_en_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic          frame_err_o,
  output logic          overrun_o
);
  logic          rx_sync, rx_vote;
  logic          frame_done, frame_ferr;
  logic [DW-1:0] frame_word;

  uart9_rx_sampler #(.SYNC_STAGES(2)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .tick_i (samp_tick_i),
    .rx_s_o (rx_sync),
    .vote_o (rx_vote)
  );

  uart9_rx_framer #(.OVS(OVS), .DW(DW)) u_framer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (samp_tick_i),
    .rx_s_i (rx_sync),
    .vote_i (rx_vote),
    .done_o (frame_done),
    .word_o (frame_word),
    .ferr_o (frame_ferr)
  );

  uart9_rx_buffer #(.DW(DW)) u_buffer (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (frame_done),
    .word_i      (frame_word),
    .ferr_i      (frame_ferr),
    .filter_en_i (addr_filter_en_i),
    .ready_i     (out_ready_i),
    .valid_o     (out_valid_o),
    .data_o      (out_data_o),
    .ferr_o      (frame_err_o),
    .overrun_o   (overrun_o)
  );
endmodule

// File: rtl/uart9_rx_checker.sv
module uart9_rx_checker #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [DW-1:0] word,
  input logic          filt,
  input logic          valid,
  input logic          ready,
  input logic [DW-1:0] data,
  input logic          ovr
);
  logic keep;
  assign keep = !filt || word[DW-1];

  a_r2_data_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    done && !keep && !valid |=> !valid);

  a_r3_r4_word_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    done && keep && !valid |=> valid && data == $past(word));

  a_r6_rise_on_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(done));

  a_r7_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));

  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    done && keep && valid && !ready |=> ovr);

  a_r9_overrun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready |=> !ovr);
endmodule

bind uart9_addr_rx uart9_rx_checker #(.DW(DW)) u_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .done  (frame_done),
  .word  (frame_word),
  .filt  (addr_filter_en_i),
  .valid (out_valid_o),
  .ready (out_ready_i),
  .data  (out_data_o),
  .ovr   (overrun_o)
);

// File: tb/test_uart9_addr_rx.sv
`timescale 1ns/1ps
module test_uart9_addr_rx;
  localparam int OVS = 16;
  localparam int DW  = 9;
  localparam int BT  = 2 * OVS;  // clocks per bit, tick every 2nd clock
  localparam int NV  = 7;
  // {filter_en, stop_level, expect_kept, word}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 9'h0A5},
    {1'b0, 1'b1, 1'b1, 9'h15A},
    {1'b1, 1'b1, 1'b0, 9'h0FF},
    {1'b1, 1'b1, 1'b1, 9'h133},
    {1'b1, 1'b0, 1'b0, 9'h044},
    {1'b0, 1'b0, 1'b1, 9'h0C3},
    {1'b1, 1'b0, 1'b1, 9'h181}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0, filt = 1'b0, ready = 1'b0;
  logic out_valid, frame_err, overrun;
  logic [DW-1:0] out_data;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart9_addr_rx #(.OVS(OVS), .DW(DW)) i_uart9_addr_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .samp_tick_i(tick),
    .addr_filter_en_i(filt), .out_valid_o(out_valid), .out_ready_i(ready),
    .out_data_o(out_data), .frame_err_o(frame_err), .overrun_o(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input logic lvl, input int n);
    rx = lvl;
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] w, input logic stop_lvl);
    @(negedge clk);
    hold_bits(1'b0, 1);
    for (int i = 0; i < DW; i++) hold_bits(w[i], 1);
    hold_bits(stop_lvl, 1);
    rx = 1'b1;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11 valid", int'(out_valid), 0);
    check(overrun == 1'b0, "R11 overrun", int'(overrun), 0);
    check(frame_err == 1'b0, "R11 frame_err", int'(frame_err), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // table walk: R1 R2 R3 R4 R8 R6
    for (int v = 0; v < NV; v++) begin
      logic kept;
      filt = VEC[v][11];
      kept = VEC[v][9];
      send_frame(VEC[v][8:0], VEC[v][10]);
      settle();
      check(out_valid == kept, "R2/R3/R4 keep", int'(out_valid), int'(kept));
      if (kept) begin
        check(out_data == VEC[v][8:0], "R1 data", int'(out_data), int'(VEC[v][8:0]));
        check(frame_err == !VEC[v][10], "R8 frame_err", int'(frame_err), int'(!VEC[v][10]));
        pop();
        check(out_valid == 1'b0, "R6 read clears", int'(out_valid), 0);
      end else begin
        check(overrun == 1'b0, "R2 no overrun", int'(overrun), 0);
        check(frame_err == 1'b0, "R8 filtered no error", int'(frame_err), 0);
      end
    end

    // R6: not valid before end of stop bit, valid after
    filt = 1'b0;
    fork
      send_frame(9'h03C, 1'b1);
      begin
        repeat (10 * BT + BT / 2) @(negedge clk);
        check(out_valid == 1'b0, "R6 no early valid", int'(out_valid), 0);
      end
    join
    settle();
    check(out_valid == 1'b1, "R6 valid at frame end", int'(out_valid), 1);
    // R7 back-pressure hold
    repeat (100) @(negedge clk);
    check(out_valid == 1'b1 && out_data == 9'h03C, "R7 hold", int'(out_data), 'h03C);
    pop();

    // R5: filter cleared mid-frame applies to this data frame
    filt = 1'b1;
    fork
      send_frame(9'h011, 1'b1);
      begin repeat (5 * BT) @(negedge clk); filt = 1'b0; end
    join
    settle();
    check(out_valid == 1'b1 && out_data == 9'h011, "R5 clear mid-frame", int'(out_data), 'h011);
    pop();
    // R5: filter set mid-frame drops this data frame
    filt = 1'b0;
    fork
      send_frame(9'h022, 1'b1);
      begin repeat (5 * BT) @(negedge clk); filt = 1'b1; end
    join
    settle();
    check(out_valid == 1'b0, "R5 set mid-frame", int'(out_valid), 0);

    // R9 overrun
    filt = 1'b0;
    send_frame(9'h101, 1'b1);
    settle();
    send_frame(9'h0EE, 1'b1);
    settle();
    check(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
    check(out_data == 9'h101, "R9 first word kept", int'(out_data), 'h101);
    pop();
    check(overrun == 1'b0 && out_valid == 1'b0, "R9 cleared by read", int'(overrun), 0);

    // R10 short glitch
    @(negedge clk);
    rx = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BT) @(negedge clk);
    check(out_valid == 1'b0, "R10 glitch ignored", int'(out_valid), 0);
    // receiver still works afterwards
    send_frame(9'h0B7, 1'b1);
    settle();
    check(out_valid == 1'b1 && out_data == 9'h0B7, "R10 recovery", int'(out_data), 'h0B7);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule